// File: doc/BRIEF.md
# Periodic Temperature Conversion Scheduler

This block decides when a temperature sensor converts and stores the result. It counts a slow time-base tick, typically one pulse per millisecond. From a 2-bit resolution code it sets how long each conversion lasts. From a 2-bit delay code it sets how far apart two conversion starts are. The converter itself is not part of the block. It is modelled by a 13-bit sample bus that the scheduler captures on the tick that closes each conversion window.

At lower resolutions the low bits of the captured value are cleared. The stored word always holds the last completed conversion, whatever the serial interface is doing at the time. A sleep request stops new conversions, but only after any conversion in progress has finished. A wake request restarts conversions on the next tick.

The resolution and delay codes are sampled at the tick that starts a conversion. A change made partway through a conversion therefore never alters that conversion's length or the interval before the next start. After reset the latched settings are 12-bit resolution and the shortest delay.

Top module: `conv_scheduler`

## Requirements
- R1: With resolution code `r` (0 = 9-bit plus sign, 1 = 10-bit, 2 = 11-bit, 3 = 12-bit), `busy` rises on the tick that starts a conversion and falls on the tick that comes `CONV_BASE << r` ticks later.
- R2: Consecutive conversion starts are `PER_BASE * m << r` ticks apart, where `m` is 1, 2, 4 or 32 for delay code 0, 1, 2 or 3.
- R3: The latched result takes the 13-bit sample present on the closing tick and clears its lowest `3 - r` bits. No bits are cleared at code 3.
- R4: `convDone` is high for exactly one clock, in the same clock that `tempOut` first shows the new result. `tempOut` does not change in any other clock.
- R5: After reset, `tempOut` is 0 and `busy` and `convDone` are low. The first tick after reset starts a conversion.
- R6: The resolution and delay codes are sampled only on a start tick. A change during a conversion affects neither that conversion's length nor the interval to the next start.
- R7: A sleep request during a conversion lets that conversion run to completion, with its result latched. No further conversion starts until a wake request arrives.
- R8: A sleep request between conversions stops all conversions at once. After a wake request, the next tick starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-clock time-base pulse |
| resSel | input | 2 | Resolution code |
| delSel | input | 2 | Delay code |
| sleepReq | input | 1 | One-clock request to stop converting |
| wakeReq | input | 1 | One-clock request to resume converting; wins over `sleepReq` |
| sampleIn | input | 13 | Raw converter result, taken on the closing tick |
| busy | output | 1 | High while a conversion window is open |
| convDone | output | 1 | One-clock strobe marking a new result |
| tempOut | output | 13 | Last completed conversion result |

## Verification
The bench sweeps all sixteen resolution and delay combinations and measures every conversion length and start-to-start interval in ticks. A design that scales only one of the two with resolution, or that decodes the 8-second delay step wrongly, gives intervals off by a power of two.

A settings change is made inside a live conversion. A design that latches the settings continuously would shorten that conversion and move the next start.

Sleep is requested both during a conversion and between conversions. A design that stops at once would lose the pending result, and one that ignores the request would keep raising `busy`.

Every result is compared with the sample masked to the resolution that was active when its conversion started. Using the current resolution instead would leave stray low bits set.

// File: rtl/convsched_pkg.sv
package convsched_pkg;

  typedef enum logic [1:0] {
    PH_ARM  = 2'd0,
    PH_CONV = 2'd1,
    PH_WAIT = 2'd2,
    PH_OFF  = 2'd3
  } phase_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic       capture;
    logic [1:0] res;
  } dp_ctrl_t;

  function automatic int unsigned delayMult(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/convsched_ctrl.sv
module convsched_ctrl
  import convsched_pkg::*;
#(
  parameter int unsigned CONV_BASE = 30,
  parameter int unsigned PER_BASE  = 31,
  parameter int unsigned CNT_W     = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic [1:0] resSel,
  input  logic [1:0] delSel,
  input  logic       sleepReq,
  input  logic       wakeReq,
  output logic       busy,
  output dp_ctrl_t   dpCtrl
);

  phase_t             phase;
  logic [CNT_W-1:0]   tickCnt;
  logic [CNT_W-1:0]   convLen;
  logic [CNT_W-1:0]   perLen;
  logic [1:0]         curRes;
  logic               sleepPend;

  logic [CNT_W-1:0]   nextCnt;
  logic [CNT_W-1:0]   newConvLen;
  logic [CNT_W-1:0]   newPerLen;
  logic               sleepNow;
  logic               endConv;
  logic               startNow;

  always_comb begin
    nextCnt    = tickCnt + 1'b1;
    newConvLen = CNT_W'(CONV_BASE) << resSel;
    newPerLen  = CNT_W'(PER_BASE * delayMult(delSel)) << resSel;
    sleepNow   = sleepReq && !wakeReq;
    endConv    = (phase == PH_CONV) && tickIn && (nextCnt == convLen);
    startNow   = tickIn && ((phase == PH_ARM) ||
                            ((phase == PH_WAIT) && (nextCnt == perLen)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_ARM;
      tickCnt   <= '0;
      convLen   <= CNT_W'(CONV_BASE) << 2'd3;
      perLen    <= CNT_W'(PER_BASE) << 2'd3;
      curRes    <= 2'd3;
      sleepPend <= 1'b0;
    end else begin
      case (phase)
        PH_ARM, PH_WAIT: begin
          if (sleepNow) begin
            phase <= PH_OFF;
          end else if (startNow) begin
            phase   <= PH_CONV;
            tickCnt <= '0;
            convLen <= newConvLen;
            perLen  <= newPerLen;
            curRes  <= resSel;
          end else if (tickIn && (phase == PH_WAIT)) begin
            tickCnt <= nextCnt;
          end
        end
        PH_CONV: begin
          if (tickIn) tickCnt <= nextCnt;
          if (endConv) begin
            phase     <= (sleepPend || sleepNow) ? PH_OFF : PH_WAIT;
            sleepPend <= 1'b0;
          end else if (wakeReq) begin
            sleepPend <= 1'b0;
          end else if (sleepReq) begin
            sleepPend <= 1'b1;
          end
        end
        default: begin
          if (wakeReq) phase <= PH_ARM;
        end
      endcase
    end
  end

  assign busy           = (phase == PH_CONV);
  assign dpCtrl.capture = endConv;
  assign dpCtrl.res     = curRes;

  // R1: the conversion window opens and closes only on a tick
  p_busy_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busy != $past(busy)) |-> $past(tickIn));

  // R2: the elapsed count stays inside the latched period
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_OFF) |-> (tickCnt < perLen));

  // R2: every period is longer than its conversion
  p_conv_shorter_r2: assert property (@(posedge clk) disable iff (!rstN)
    convLen < perLen);

  // R7: asleep means no conversion window in the next clock
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OFF) |=> !busy);

  // R7: a pending sleep exists only while a conversion runs
  p_pend_in_conv_r7: assert property (@(posedge clk) disable iff (!rstN)
    sleepPend |-> (phase == PH_CONV));

endmodule

// File: rtl/convsched_dpath.sv
module convsched_dpath
  import convsched_pkg::*;
#(
  parameter int unsigned TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          dpCtrl,
  input  logic [TEMP_W-1:0] sampleIn,
  output logic              convDone,
  output logic [TEMP_W-1:0] tempOut
);

  logic [TEMP_W-1:0] keepMask;

  always_comb begin
    keepMask = {TEMP_W{1'b1}} << (2'd3 - dpCtrl.res);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempOut  <= '0;
      convDone <= 1'b0;
    end else begin
      convDone <= dpCtrl.capture;
      if (dpCtrl.capture) tempOut <= sampleIn & keepMask;
    end
  end

  // R4: the result moves only together with the strobe
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |-> $stable(tempOut));

  // R4: the strobe never lasts two clocks
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  // R3: the unused low bits of a fresh result are clear
  p_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    convDone |->
      ((tempOut & ~({TEMP_W{1'b1}} << (2'd3 - $past(dpCtrl.res)))) == '0));

endmodule

// File: rtl/conv_scheduler.sv
module conv_scheduler
  import convsched_pkg::*;
#(
  parameter int unsigned CONV_BASE = 30,
  parameter int unsigned PER_BASE  = 31,
  parameter int unsigned TEMP_W    = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [1:0]        resSel,
  input  logic [1:0]        delSel,
  input  logic              sleepReq,
  input  logic              wakeReq,
  input  logic [TEMP_W-1:0] sampleIn,
  output logic              busy,
  output logic              convDone,
  output logic [TEMP_W-1:0] tempOut
);

  localparam int unsigned MAX_PER = PER_BASE * 32 * 8;
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);

  dp_ctrl_t dpCtrl;

  convsched_ctrl #(
    .CONV_BASE(CONV_BASE),
    .PER_BASE (PER_BASE),
    .CNT_W    (CNT_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (tickIn),
    .resSel  (resSel),
    .delSel  (delSel),
    .sleepReq(sleepReq),
    .wakeReq (wakeReq),
    .busy    (busy),
    .dpCtrl  (dpCtrl)
  );

  convsched_dpath #(
    .TEMP_W(TEMP_W)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .sampleIn(sampleIn),
    .convDone(convDone),
    .tempOut (tempOut)
  );

endmodule

// File: tb/conv_scheduler_test.sv
module conv_scheduler_test;

  localparam int CLK_PERIOD = 10;
  localparam int CB = 3;
  localparam int PB = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [1:0]  resSel = 2'd3;
  logic [1:0]  delSel = 2'd0;
  logic        sleepReq = 1'b0;
  logic        wakeReq = 1'b0;
  logic [12:0] sampleIn = '0;
  logic        busy;
  logic        convDone;
  logic [12:0] tempOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_scheduler #(.CONV_BASE(CB), .PER_BASE(PB), .TEMP_W(13)) uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .resSel(resSel), .delSel(delSel),
    .sleepReq(sleepReq), .wakeReq(wakeReq), .sampleIn(sampleIn),
    .busy(busy), .convDone(convDone), .tempOut(tempOut)
  );

  int nChecks = 0;
  int nFail = 0;
  int tickNo = 0;
  bit prevBusy = 1'b0;
  bit rose = 1'b0;
  bit fell = 1'b0;
  int roseTick = 0;
  int fellTick = 0;
  logic [1:0]  resAtStart = 2'd3;
  logic [12:0] lastTemp = '0;
  logic [12:0] drivenSample = '0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mult(input logic [1:0] d);
    case (d)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 32;
    endcase
  endfunction

  function automatic logic [12:0] masked(input logic [12:0] v, input logic [1:0] r);
    int drop;
    drop = 3 - int'(r);
    return v & ~13'((1 << drop) - 1);
  endfunction

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  // One tick: drive sample and tick, then sample outputs away from the edge
  task automatic stepTick();
    @(negedge clk);
    chk(convDone == 1'b0, "R4 strobe one clock", int'(convDone), 0);
    drivenSample = 13'((tickNo * 733 + 5) ^ 13'h1ABC);
    sampleIn = drivenSample;
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
    tickNo++;
    rose = busy && !prevBusy;
    fell = !busy && prevBusy;
    prevBusy = busy;
    if (rose) begin
      roseTick = tickNo;
      resAtStart = resSel;
    end
    if (fell) fellTick = tickNo;
    if (convDone != fell)
      chk(1'b0, "R4 strobe with end of window", int'(convDone), int'(fell));
    if (fell) begin
      chk(tempOut == masked(drivenSample, resAtStart), "R3 masked result",
          int'(tempOut), int'(masked(drivenSample, resAtStart)));
      lastTemp = tempOut;
    end else if (tempOut != lastTemp) begin
      chk(1'b0, "R4 result held", int'(tempOut), int'(lastTemp));
    end
  endtask

  task automatic waitRise();
    for (int i = 0; i < 5000; i++) begin
      stepTick();
      if (rose) return;
    end
    chk(1'b0, "R2 start expected", 0, 1);
  endtask

  task automatic waitFall();
    for (int i = 0; i < 5000; i++) begin
      stepTick();
      if (fell) return;
    end
    chk(1'b0, "R1 end expected", 0, 1);
  endtask

  task automatic pulseSleep();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeReq = 1'b1;
    @(negedge clk); wakeReq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishUp();
  end

  initial begin
    int a;
    int rises;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: reset state
    chk(busy == 1'b0, "R5 busy after reset", int'(busy), 0);
    chk(convDone == 1'b0, "R5 done after reset", int'(convDone), 0);
    chk(tempOut == 13'd0, "R5 result after reset", int'(tempOut), 0);
    stepTick();
    chk(rose, "R5 first tick starts", int'(rose), 1);
    waitFall();
    chk(fellTick - roseTick == (CB << 3), "R5 default 12-bit length",
        fellTick - roseTick, CB << 3);

    // R1 R2: sweep every resolution and delay code
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 4; d++) begin
        resSel = 2'(r);
        delSel = 2'(d);
        waitRise();
        a = roseTick;
        waitFall();
        chk(fellTick - a == (CB << r), "R1 conversion length", fellTick - a, CB << r);
        waitRise();
        chk(roseTick - a == ((PB * mult(2'(d))) << r), "R2 start period",
            roseTick - a, (PB * mult(2'(d))) << r);
      end
    end

    // R6: settings changed mid-conversion apply from the next start
    resSel = 2'd3; delSel = 2'd0;
    waitRise();
    waitRise();
    a = roseTick;
    resSel = 2'd0; delSel = 2'd3;
    waitFall();
    chk(fellTick - a == (CB << 3), "R6 length kept", fellTick - a, CB << 3);
    waitRise();
    chk(roseTick - a == (PB << 3), "R6 period kept", roseTick - a, PB << 3);
    a = roseTick;
    waitFall();
    chk(fellTick - a == CB, "R6 new length next", fellTick - a, CB);

    // R7: sleep during a conversion
    resSel = 2'd1; delSel = 2'd1;
    waitRise();
    waitRise();
    a = roseTick;
    pulseSleep();
    waitFall();
    chk(fellTick - a == (CB << 1), "R7 conversion completes", fellTick - a, CB << 1);
    rises = 0;
    for (int i = 0; i < 60; i++) begin
      stepTick();
      if (busy) rises++;
    end
    chk(rises == 0, "R7 no start while asleep", rises, 0);
    pulseWake();
    stepTick();
    chk(rose, "R7 wake restarts", int'(rose), 1);

    // R8: sleep between conversions
    waitFall();
    pulseSleep();
    rises = 0;
    for (int i = 0; i < 60; i++) begin
      stepTick();
      if (busy) rises++;
    end
    chk(rises == 0, "R8 no start while asleep", rises, 0);
    pulseWake();
    stepTick();
    chk(rose, "R8 next tick starts", int'(rose), 1);
    a = roseTick;
    waitFall();
    chk(fellTick - a == (CB << 1), "R8 length after wake", fellTick - a, CB << 1);

    finishUp();
  end

endmodule